// File: doc/BRIEF.md
# FIFO Flag Offset Programmer

This block owns the two threshold registers that a FIFO's almost-empty and almost-full flag comparators read: the empty-side offset and the full-side offset. While master reset is held, three strap inputs (the load line and a two-bit select) pick one of eight built-in default offset pairs. The load strap also fixes which programming method is allowed until the next master reset:
- parallel, through the 18-bit data ports;
- serial, through a slow serial clock with an enable.

A parity strap is captured at the same time. It decides which data bits carry offset payload and which are treated as parity.

After reset, pulling the load line low opens the offsets to the host. While load is low, a flag output tells the surrounding FIFO to suspend its normal data traffic. Parallel write cycles fill the empty offset first and then the full offset, and the order then repeats. Parallel read cycles return the offsets in the same order. Readback is always parallel, whichever method was chosen for writing.

In serial mode, bits arrive least significant bit first on the serial clock. The serial clock, enable and data are synchronised into the main clock domain. After twice the offset width in accepted bits, both offsets are replaced at once.

Top module: `fifo_offset_prog`

## Requirements
- R1: After a master reset, both offsets equal 2^(k+3)-1, truncated to OFS_W bits. Here k = {ld_n, fsel[1], fsel[0]} as sampled on the last clock edge of reset, with ld_n as the most significant bit.
- R2: A high ld_n at reset selects parallel writing and a low ld_n selects serial writing. Until the next reset, the method that was not chosen has no effect on the offsets.
- R3: In parallel mode, each clock edge with ld_n low and wr_en high writes an offset, visible on the outputs after that edge. Writes go to the empty offset, then the full offset, alternately. The order restarts at the empty offset whenever ld_n is high.
- R4: Each clock edge with ld_n low and rd_en high places one offset on rd_q, alternating empty then full. The order restarts at the empty offset whenever ld_n is high. Readback works in both programming modes.
- R5: With the parity strap high at reset (interspersed parity), the payload is {d[16:9], d[7:0]}, of which the low OFS_W bits are used. Readback drives rd_q = {0, p[15:8], 0, p[7:0]}, so rd_q[8] and rd_q[17] read 0.
- R6: With the parity strap low, the payload is d[15:0]. Readback drives rd_q = {2'b00, p[15:0]}.
- R7: In serial mode with ld_n low, each rising sclk edge that has sen_n low shifts in si, least significant bit first. Edges with sen_n high are ignored. After 2*OFS_W accepted bits:
  - the first OFS_W bits become the empty offset and the next OFS_W bits become the full offset;
  - the offsets are unchanged before that point;
  - the bit count restarts whenever ld_n is high.
- R8: fifo_block is 1 exactly when master reset is released and ld_n is low.
- R9: With ld_n high, wr_en and rd_en have no effect: the offsets and rd_q hold.
- R10: The parity mode captured at reset holds until the next reset, whatever the parity strap does afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| mrst_n | input | 1 | Master reset, active low, synchronous; straps are sampled while low |
| ld_n | input | 1 | Load strap during reset; offset access enable (active low) afterwards |
| fsel | input | 2 | Default-offset select straps |
| ip_strap | input | 1 | Parity layout strap: 1 interspersed, 0 non-interspersed |
| wr_en | input | 1 | Parallel offset write strobe |
| wr_d | input | 18 | Parallel write data |
| rd_en | input | 1 | Parallel offset read strobe |
| rd_q | output | 18 | Parallel readback data (registered) |
| sclk | input | 1 | Serial load clock (slow, synchronised internally) |
| sen_n | input | 1 | Serial enable, active low |
| si | input | 1 | Serial data in |
| empty_ofs | output | OFS_W | Almost-empty offset |
| full_ofs | output | OFS_W | Almost-full offset |
| fifo_block | output | 1 | Suspends normal FIFO traffic during programming |

## Verification
The bench sweeps every strap code under both parity layouts and computes each default and each packed readback word arithmetically.

It targets the write-order restart when load goes high. A design that kept its pointer across that point would send the next write into the full offset.

It also checks each programming path while the other method is selected. A design that left both paths open would let a stray parallel write or a serial bit stream corrupt an offset.

For serial loading, it checks four things:
- the offsets stay unchanged halfway through the stream;
- a clock edge with the enable high is dropped;
- an aborted partial stream does not shift later bits out of place;
- the parity layout does not follow a strap change made after reset. A design that misplaced bits would put payload on rd_q bit 8 or bit 17, or on bits 17:16.

// File: rtl/fifo_offset_prog.sv
module fifo_offset_prog #(
  parameter int OFS_W = 10
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic             ld_n,
  input  logic [1:0]       fsel,
  input  logic             ip_strap,
  input  logic             wr_en,
  input  logic [17:0]      wr_d,
  input  logic             rd_en,
  output logic [17:0]      rd_q,
  input  logic             sclk,
  input  logic             sen_n,
  input  logic             si,
  output logic [OFS_W-1:0] empty_ofs,
  output logic [OFS_W-1:0] full_ofs,
  output logic             fifo_block
);
  localparam int SER_BITS = 2 * OFS_W;
  localparam int CNT_W    = $clog2(SER_BITS + 1);

  logic                ser_mode, ip_mode;
  logic                wptr, rptr;
  logic [CNT_W-1:0]    bit_cnt;
  logic [SER_BITS-1:0] shreg;
  logic [2:0]          sclk_s;
  logic [1:0]          si_s, sen_s;

  function automatic logic [OFS_W-1:0] dflt(input logic [2:0] k);
    return OFS_W'((32'd1 << (32'(k) + 32'd3)) - 32'd1);
  endfunction

  logic [15:0]         wr_pay, rd_pay;
  logic [OFS_W-1:0]    wr_val;
  logic [17:0]         rd_word;
  logic                sclk_rise, shift_en, ser_done, par_wr, par_rd;
  logic [SER_BITS-1:0] shreg_nx;

  assign wr_pay    = ip_mode ? {wr_d[16:9], wr_d[7:0]} : wr_d[15:0];
  assign wr_val    = wr_pay[OFS_W-1:0];
  assign rd_pay    = 16'(rptr ? full_ofs : empty_ofs);
  assign rd_word   = ip_mode ? {1'b0, rd_pay[15:8], 1'b0, rd_pay[7:0]} : {2'b00, rd_pay};

  assign fifo_block = mrst_n & ~ld_n;
  assign par_wr    = ~ser_mode & ~ld_n & wr_en;
  assign par_rd    = ~ld_n & rd_en;
  assign sclk_rise = sclk_s[1] & ~sclk_s[2];
  assign shift_en  = ser_mode & ~ld_n & sclk_rise & ~sen_s[1];
  assign shreg_nx  = {si_s[1], shreg[SER_BITS-1:1]};
  assign ser_done  = shift_en && (bit_cnt == CNT_W'(SER_BITS - 1));

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      sclk_s <= '0;
      si_s   <= '0;
      sen_s  <= '1;
    end else begin
      sclk_s <= {sclk_s[1:0], sclk};
      si_s   <= {si_s[0], si};
      sen_s  <= {sen_s[0], sen_n};
    end
  end

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      ser_mode  <= ~ld_n;
      ip_mode   <= ip_strap;
      empty_ofs <= dflt({ld_n, fsel});
      full_ofs  <= dflt({ld_n, fsel});
      wptr      <= 1'b0;
      rptr      <= 1'b0;
      bit_cnt   <= '0;
      shreg     <= '0;
      rd_q      <= '0;
    end else if (ld_n) begin
      wptr    <= 1'b0;
      rptr    <= 1'b0;
      bit_cnt <= '0;
    end else begin
      if (par_wr) begin
        if (wptr) full_ofs  <= wr_val;
        else      empty_ofs <= wr_val;
        wptr <= ~wptr;
      end
      if (par_rd) begin
        rd_q <= rd_word;
        rptr <= ~rptr;
      end
      if (shift_en) begin
        shreg <= shreg_nx;
        if (ser_done) begin
          bit_cnt   <= '0;
          empty_ofs <= shreg_nx[OFS_W-1:0];
          full_ofs  <= shreg_nx[SER_BITS-1:OFS_W];
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fifo_offset_prog_chk.sv
module fifo_offset_prog_chk #(
  parameter int OFS_W = 10
) (
  input logic             clk,
  input logic             mrst_n,
  input logic             ld_n,
  input logic             wr_en,
  input logic             rd_en,
  input logic             ser_mode,
  input logic             ip_mode,
  input logic [17:0]      rd_q,
  input logic [OFS_W-1:0] empty_ofs,
  input logic [OFS_W-1:0] full_ofs
);
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!mrst_n)
    ld_n |=> ($stable(empty_ofs) && $stable(full_ofs) && $stable(rd_q)));

  assert_par_only_R2: assert property (@(posedge clk) disable iff (!mrst_n)
    (!ser_mode && !(wr_en && !ld_n)) |=> ($stable(empty_ofs) && $stable(full_ofs)));

  assert_rdq_quiet_R4: assert property (@(posedge clk) disable iff (!mrst_n)
    !(rd_en && !ld_n) |=> $stable(rd_q));

  assert_ip_layout_R5: assert property (@(posedge clk) disable iff (!mrst_n)
    ip_mode |-> (rd_q[8] == 1'b0 && rd_q[17] == 1'b0));

  assert_nip_layout_R6: assert property (@(posedge clk) disable iff (!mrst_n)
    !ip_mode |-> (rd_q[17:16] == 2'b00));

  assert_mode_held_R10: assert property (@(posedge clk) disable iff (!mrst_n)
    mrst_n |=> ($stable(ip_mode) && $stable(ser_mode)));
endmodule

bind fifo_offset_prog fifo_offset_prog_chk #(.OFS_W(OFS_W)) u_chk (
  .clk(clk), .mrst_n(mrst_n), .ld_n(ld_n), .wr_en(wr_en), .rd_en(rd_en),
  .ser_mode(ser_mode), .ip_mode(ip_mode), .rd_q(rd_q),
  .empty_ofs(empty_ofs), .full_ofs(full_ofs)
);

// File: tb/tb_fifo_offset_prog.sv
module tb_fifo_offset_prog;
  localparam int W = 10;

  logic clk = 0, mrst_n = 0, ld_n = 1, ip_strap = 0;
  logic [1:0] fsel = 0;
  logic wr_en = 0, rd_en = 0, sclk = 0, sen_n = 1, si = 0;
  logic [17:0] wr_d = 0, rd_q;
  logic [W-1:0] empty_ofs, full_ofs;
  logic fifo_block;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fifo_offset_prog #(.OFS_W(W)) dut (.*);

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [W-1:0] ext(logic [17:0] d, logic ip);
    logic [15:0] p;
    p = ip ? {d[16:9], d[7:0]} : d[15:0];
    return p[W-1:0];
  endfunction

  function automatic logic [17:0] pack(logic [W-1:0] v, logic ip);
    logic [15:0] p;
    p = 16'(v);
    return ip ? {1'b0, p[15:8], 1'b0, p[7:0]} : {2'b00, p};
  endfunction

  function automatic logic [W-1:0] dval(int k);
    return W'((1 << (k + 3)) - 1);
  endfunction

  task automatic do_reset(input logic [2:0] k, input logic ip);
    mrst_n = 0; ld_n = k[2]; fsel = k[1:0]; ip_strap = ip;
    wr_en = 0; rd_en = 0; sclk = 0; sen_n = 1; si = 0;
    repeat (3) tick();
    check("R8 block in reset", fifo_block, 0);
    mrst_n = 1; tick();
    ld_n = 1; tick();
  endtask

  task automatic sbit(input logic b, input logic en_n);
    si = b; sen_n = en_n; repeat (2) tick();
    sclk = 1; repeat (4) tick();
    sclk = 0; repeat (4) tick();
  endtask

  task automatic readback(input logic [W-1:0] e, input logic [W-1:0] f, input logic ip, string tag);
    ld_n = 0; rd_en = 1; tick();
    check({tag, " empty"}, rd_q, pack(e, ip));
    tick();
    check({tag, " full"}, rd_q, pack(f, ip));
    rd_en = 0; ld_n = 1; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1/R8 defaults across all strap codes and both parity layouts
    for (int ip = 0; ip < 2; ip++) begin
      for (int k = 0; k < 8; k++) begin
        do_reset(3'(k), 1'(ip));
        check("R1 default empty", empty_ofs, dval(k));
        check("R1 default full", full_ofs, dval(k));
        check("R8 block idle", fifo_block, 0);
        ld_n = 0; #1;
        check("R8 block active", fifo_block, 1);
        ld_n = 1; tick();
        readback(dval(k), dval(k), 1'(ip), "R4 default readback");
      end
    end

    // R3/R5/R6 parallel write order and restart, both layouts
    for (int ip = 0; ip < 2; ip++) begin
      logic [17:0] a, b, c, d;
      a = 18'h2A5F3; b = 18'h1C3B6; c = 18'h3FFFF; d = 18'h00155;
      do_reset(3'b110, 1'(ip));
      ld_n = 0; wr_en = 1;
      wr_d = a; tick(); check("R3 first write empty", empty_ofs, ext(a, 1'(ip)));
      wr_d = b; tick(); check("R3 second write full", full_ofs, ext(b, 1'(ip)));
      wr_d = c; tick(); check("R3 third write empty", empty_ofs, ext(c, 1'(ip)));
      check("R3 full kept", full_ofs, ext(b, 1'(ip)));
      wr_en = 0; ld_n = 1; tick();
      ld_n = 0; wr_en = 1; wr_d = d; tick();
      check("R3 restart empty", empty_ofs, ext(d, 1'(ip)));
      check("R3 restart full kept", full_ofs, ext(b, 1'(ip)));
      wr_en = 0; ld_n = 1; tick();
      readback(ext(d, 1'(ip)), ext(b, 1'(ip)), 1'(ip), ip ? "R5 readback" : "R6 readback");
      // read pointer restart
      ld_n = 0; rd_en = 1; tick(); rd_en = 0; ld_n = 1; tick();
      ld_n = 0; rd_en = 1; tick();
      check("R4 read restart", rd_q, pack(ext(d, 1'(ip)), 1'(ip)));
      rd_en = 0; ld_n = 1; tick();
      // R9 ignored strobes with load high
      wr_en = 1; wr_d = 18'h12345; rd_en = 1; repeat (3) tick();
      wr_en = 0; rd_en = 0;
      check("R9 empty held", empty_ofs, ext(d, 1'(ip)));
      check("R9 full held", full_ofs, ext(b, 1'(ip)));
      check("R9 rd_q held", rd_q, pack(ext(d, 1'(ip)), 1'(ip)));
      // R2 serial bits ignored in parallel mode
      ld_n = 0;
      for (int i = 0; i < 2 * W; i++) sbit(1'b1, 1'b0);
      ld_n = 1; tick();
      check("R2 serial ignored empty", empty_ofs, ext(d, 1'(ip)));
      check("R2 serial ignored full", full_ofs, ext(b, 1'(ip)));
    end

    // R10 parity layout held after strap change
    do_reset(3'b100, 1'b1);
    ip_strap = 0;
    ld_n = 0; wr_en = 1; wr_d = 18'h3FFFF; tick(); wr_d = 18'h3FFFF; tick();
    wr_en = 0; ld_n = 1; tick();
    readback(ext(18'h3FFFF, 1'b1), ext(18'h3FFFF, 1'b1), 1'b1, "R10 layout held");

    // R2/R7 serial mode
    begin
      logic [2*W-1:0] v;
      v = {10'h2C7, 10'h135};
      do_reset(3'b010, 1'b0);
      ld_n = 0; wr_en = 1; wr_d = 18'h00077; tick(); tick(); wr_en = 0;
      check("R2 parallel ignored empty", empty_ofs, dval(2));
      check("R2 parallel ignored full", full_ofs, dval(2));
      for (int i = 0; i < 3; i++) sbit(1'b1, 1'b0);
      ld_n = 1; tick(); ld_n = 0;
      for (int i = 0; i < 2 * W; i++) begin
        if (i == 5) sbit(~v[i], 1'b1);
        sbit(v[i], 1'b0);
        if (i == W) begin
          check("R7 mid-stream empty", empty_ofs, dval(2));
          check("R7 mid-stream full", full_ofs, dval(2));
        end
      end
      ld_n = 1; tick();
      check("R7 serial empty", empty_ofs, v[W-1:0]);
      check("R7 serial full", full_ofs, v[2*W-1:W]);
      readback(v[W-1:0], v[2*W-1:W], 1'b0, "R4 serial-mode readback");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule